// File: doc/BRIEF.md
# Parallel Disk Register Access Engine

This block sits on the host side of a 40-pin parallel disk cable and carries out one register access at a time, in the slowest programmed-I/O timing. A requester hands it an access with a valid/ready handshake. The access names:

- the chip-select pair,
- a 3-bit register address,
- the direction,
- a width flag,
- the write data.

The engine then runs a fixed sequence on the cable: turn the data bus, present address and selects, pulse the read or write strobe, hold, and release. Read data returns with a one-cycle done pulse.

The engine drives all address and control lines, which are always outputs. It owns the direction of the 16-bit data bus through an output enable, and the enable changes only while every active-low control sits at its inactive level. It also drives the cable's active-low hardware reset line. That line goes low only while a reset request is being served. Setup, strobe, hold and reset lengths are parameters counted in clock cycles. Their defaults meet the slowest timing mode with a 5 ns clock: 70 ns setup, 170 ns strobe, and about 600 ns for the full cycle.

Back-pressure: `req_ready` is high only while the engine is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. The request fields must be stable in that cycle and are ignored at every other time. The response has no back-pressure. `rsp_valid` is a single-cycle pulse that the requester must take when it appears.

Top module: `pdisk_pio_engine`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `bus_cs0_n`, `bus_cs1_n`, `bus_rd_n`, `bus_wr_n` and `bus_rst_n` are all 1, `bus_d_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only when idle. A request presented while busy leaves the running access unchanged and starts nothing. Each accepted request produces exactly one strobe pulse, or one reset pulse.
- R3: `bus_d_oe` is 1 from the cycle after acceptance of a write until the selects are released, and 0 for reads. It changes only in cycles where all five active-low controls are 1.
- R4: Address and selects are presented exactly `SETUP_CYC` cycles before the strobe falls. In the cycle between acceptance and that point, all controls are inactive.
- R5: The strobe (`bus_rd_n` for reads, `bus_wr_n` for writes) is low for exactly `STROBE_CYC` cycles, and both strobes are never low together.
- R6: Address and selects stay unchanged for exactly `HOLD_CYC` cycles after the strobe rises, then both selects go to 1.
- R7: `rsp_valid` pulses for one cycle, in the cycle where the selects are released (or `bus_rst_n` returns high). For a read, `rsp_rdata` then holds `bus_d_in` as sampled in the last strobe-low cycle.
- R8: An access is 16 bits wide only when `req_wide` is 1, `req_cs` is 2'b01 and `req_addr` is 0. Every other access is 8 bits wide: read data bits 15:8 return 0, and write data bits 15:8 are driven 0.
- R9: During a write, `bus_d_out` carries the write data from the start of setup through the last hold cycle.
- R10: A request with `req_hwrst` = 1 drives `bus_rst_n` low for exactly `RESET_CYC` cycles, with selects and strobes inactive, then gives a done pulse. At no other time is `bus_rst_n` low.
- R11: Select encoding: `req_cs[0]` = 1 drives `bus_cs0_n` low and `req_cs[1]` = 1 drives `bus_cs1_n` low, from setup through hold only. `bus_addr` equals `req_addr` over the same span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_hwrst | input | 1 | Request is a hardware reset pulse |
| req_write | input | 1 | 1 write, 0 read |
| req_cs | input | 2 | Select pair, bit0 primary, bit1 alternate, 1 = active |
| req_addr | input | 3 | Register address |
| req_wide | input | 1 | Ask for a 16-bit access |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 16 | Read data |
| bus_rst_n | output | 1 | Cable hardware reset, active low |
| bus_cs0_n | output | 1 | Primary chip select, active low |
| bus_cs1_n | output | 1 | Alternate chip select, active low |
| bus_addr | output | 3 | Cable register address |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_d_oe | output | 1 | Data bus driven by the host |
| bus_d_out | output | 16 | Data driven onto the cable |
| bus_d_in | input | 16 | Data read from the cable |

## Verification
The hardest case to reach from the ports is a request arriving while an access is running, because a careful requester never sends one. The bench therefore holds `req_valid` high with inverted fields for many cycles mid-access on chosen accesses. It then checks that the bus keeps the original access and that the count of strobes equals the count of accepted requests. Read sampling at the last strobe cycle is reached by driving a decoy word on `bus_d_in` whenever the read strobe is high. Width decoding is covered by random accesses mixed with directed cases at the data register under both selects.

// File: rtl/pdisk_pio_pkg.sv
package pdisk_pio_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_TURN   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4,
    PH_HWRST  = 3'd5
  } pio_phase_e;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 3;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pdisk_phase_timer.sv
module pdisk_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pdisk_cycle_seq.sv
module pdisk_cycle_seq
  import pdisk_pio_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 14,
  parameter int unsigned STROBE_CYC = 34,
  parameter int unsigned HOLD_CYC   = 72,
  parameter int unsigned RESET_CYC  = 5000,
  parameter int unsigned CNT_W      = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             fire_hwrst,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output pio_phase_e       phase,
  output logic             done_pulse
);

  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RESET_LD  = CNT_W'(RESET_CYC - 1);

  pio_phase_e phase_q, phase_d;
  logic       finish;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    finish   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (fire) begin
          tmr_load = 1'b1;
          if (fire_hwrst) begin
            phase_d = PH_HWRST;
            tmr_val = RESET_LD;
          end else begin
            phase_d = PH_TURN;
          end
        end
      end
      PH_TURN: begin
        phase_d  = PH_SETUP;
        tmr_load = 1'b1;
        tmr_val  = SETUP_LD;
      end
      PH_SETUP: begin
        if (tmr_expired) begin
          phase_d  = PH_STROBE;
          tmr_load = 1'b1;
          tmr_val  = STROBE_LD;
        end
      end
      PH_STROBE: begin
        if (tmr_expired) begin
          phase_d  = PH_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LD;
        end
      end
      PH_HOLD, PH_HWRST: begin
        if (tmr_expired) begin
          phase_d = PH_IDLE;
          finish  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      done_pulse <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      done_pulse <= finish;
    end
  end

  assign phase = phase_q;

  AST_FIRE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> (phase_q != PH_TURN) && (phase_q != PH_HWRST || $past(phase_q) == PH_HWRST)) else $error("busy fire"); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse) else $error("done width"); // R7

endmodule

// File: rtl/pdisk_data_path.sv
module pdisk_data_path
  import pdisk_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              req_write,
  input  logic [1:0]        req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              sample_en,
  input  logic [DATA_W-1:0] bus_d_in,
  output logic              write_q,
  output logic [1:0]        cs_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] d_out,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned HALF = DATA_W / 2;

  logic              wide_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      cs_q    <= '0;
      addr_q  <= '0;
      wide_q  <= 1'b0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      if (fire) begin
        write_q <= req_write;
        cs_q    <= req_cs;
        addr_q  <= req_addr;
        wide_q  <= req_wide && (req_cs == 2'b01) && (req_addr == '0);
        wdata_q <= req_wdata;
      end
      if (sample_en) begin
        rdata <= wide_q ? bus_d_in : {{HALF{1'b0}}, bus_d_in[HALF-1:0]};
      end
    end
  end

  assign d_out = wide_q ? wdata_q : {{HALF{1'b0}}, wdata_q[HALF-1:0]};

  AST_NARROW_ONLY_DATA_REG: assert property (@(posedge clk) disable iff (!rst_n)
    wide_q |-> (cs_q == 2'b01) && (addr_q == '0)) else $error("wide off data reg"); // R8
  AST_NARROW_READ_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_q && $past(sample_en)) |-> (rdata[DATA_W-1:HALF] == '0)) else $error("upper byte"); // R8

endmodule

// File: rtl/pdisk_pio_engine.sv
module pdisk_pio_engine
  import pdisk_pio_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 14,
  parameter int unsigned STROBE_CYC = 34,
  parameter int unsigned HOLD_CYC   = 72,
  parameter int unsigned RESET_CYC  = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_hwrst,
  input  logic        req_write,
  input  logic [1:0]  req_cs,
  input  logic [2:0]  req_addr,
  input  logic        req_wide,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic        bus_rst_n,
  output logic        bus_cs0_n,
  output logic        bus_cs1_n,
  output logic [2:0]  bus_addr,
  output logic        bus_rd_n,
  output logic        bus_wr_n,
  output logic        bus_d_oe,
  output logic [15:0] bus_d_out,
  input  logic [15:0] bus_d_in
);

  localparam int unsigned MAX_LEN = max4(SETUP_CYC, STROBE_CYC, HOLD_CYC, RESET_CYC);
  localparam int unsigned CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  pio_phase_e       phase;
  logic             fire;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             sample_en;
  logic             write_q;
  logic [1:0]       cs_q;
  logic [2:0]       addr_q;
  logic             sel_on;
  logic             in_access;

  assign req_ready = (phase == PH_IDLE);
  assign fire      = req_valid && req_ready;

  pdisk_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  pdisk_cycle_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .RESET_CYC  (RESET_CYC),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .fire_hwrst  (req_hwrst),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .phase       (phase),
    .done_pulse  (rsp_valid)
  );

  assign sample_en = (phase == PH_STROBE) && tmr_expired && !write_q;

  pdisk_data_path u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .req_write (req_write),
    .req_cs    (req_cs),
    .req_addr  (req_addr),
    .req_wide  (req_wide),
    .req_wdata (req_wdata),
    .sample_en (sample_en),
    .bus_d_in  (bus_d_in),
    .write_q   (write_q),
    .cs_q      (cs_q),
    .addr_q    (addr_q),
    .d_out     (bus_d_out),
    .rdata     (rsp_rdata)
  );

  assign sel_on    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign in_access = sel_on || (phase == PH_TURN);

  assign bus_cs0_n = !(sel_on && cs_q[0]);
  assign bus_cs1_n = !(sel_on && cs_q[1]);
  assign bus_addr  = sel_on ? addr_q : 3'b000;
  assign bus_rd_n  = !((phase == PH_STROBE) && !write_q);
  assign bus_wr_n  = !((phase == PH_STROBE) && write_q);
  assign bus_d_oe  = in_access && write_q;
  assign bus_rst_n = (phase != PH_HWRST);

  AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_d_oe) |-> bus_cs0_n && bus_cs1_n && bus_rd_n && bus_wr_n && bus_rst_n) else $error("turn with control active"); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)) else $error("both strobes"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_cs0_n && bus_cs1_n && bus_rd_n && bus_wr_n && bus_rst_n && !bus_d_oe) else $error("idle not quiet"); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |=> $stable(bus_addr) && $stable(bus_cs0_n) && $stable(bus_cs1_n)) else $error("addr moved"); // R6
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |-> bus_cs0_n && bus_cs1_n && bus_rd_n && bus_wr_n && !bus_d_oe) else $error("reset not clean"); // R10
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_d_oe && $past(bus_d_oe)) |-> $stable(bus_d_out)) else $error("write data moved"); // R9

endmodule

// File: tb/pdisk_pio_engine_tb.sv
module pdisk_pio_engine_tb;

  localparam int SETUP  = 14;
  localparam int STROBE = 34;
  localparam int HOLD   = 72;
  localparam int RSTLEN = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_hwrst = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_cs = 2'b01;
  logic [2:0]  req_addr = 3'd0;
  logic        req_wide = 1'b0;
  logic [15:0] req_wdata = 16'h0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        bus_rst_n, bus_cs0_n, bus_cs1_n, bus_rd_n, bus_wr_n, bus_d_oe;
  logic [2:0]  bus_addr;
  logic [15:0] bus_d_out;
  logic [15:0] bus_d_in;
  logic [15:0] dev_word = 16'h0;

  int checks = 0;
  int fails = 0;
  int issued = 0;
  int seen = 0;

  bit          exp_write;
  logic [1:0]  exp_cs;
  logic [2:0]  exp_addr;
  logic [15:0] exp_bus;

  always #2.5 clk = ~clk;

  assign bus_d_in = !bus_rd_n ? dev_word : ~dev_word;

  pdisk_pio_engine #(
    .SETUP_CYC(SETUP), .STROBE_CYC(STROBE), .HOLD_CYC(HOLD), .RESET_CYC(RSTLEN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_hwrst(req_hwrst),
    .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr),
    .req_wide(req_wide), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_rst_n(bus_rst_n), .bus_cs0_n(bus_cs0_n), .bus_cs1_n(bus_cs1_n),
    .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_d_oe(bus_d_oe), .bus_d_out(bus_d_out), .bus_d_in(bus_d_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic bit is_wide(input bit wide, input logic [1:0] cs, input logic [2:0] a);
    return wide && (cs == 2'b01) && (a == 3'd0);
  endfunction

  function automatic logic [15:0] shape(input bit wide, input logic [1:0] cs,
                                        input logic [2:0] a, input logic [15:0] v);
    return is_wide(wide, cs, a) ? v : {8'h00, v[7:0]};
  endfunction

  // bus monitor, sampled away from the active edge
  int  setup_cnt = 0, strobe_cnt = 0, hold_cnt = 0, rst_cnt = 0;
  bit  got_strobe = 0;
  bit  p_sel = 0, p_stb = 0, p_oe = 0, p_rstn = 1;
  bit  rst_clean = 1;

  always @(negedge clk) begin
    bit sel, stb;
    if (rst_n) begin
      sel = !bus_cs0_n || !bus_cs1_n;
      stb = !bus_rd_n || !bus_wr_n;
      if (!bus_rd_n && !bus_wr_n) chk(0, "R5 both strobes low", 2'b00, 2'b11);
      if (bus_d_oe != p_oe)
        chk(bus_cs0_n && bus_cs1_n && bus_rd_n && bus_wr_n && bus_rst_n,
            "R3 direction change with control active",
            {bus_cs0_n, bus_cs1_n, bus_rd_n, bus_wr_n, bus_rst_n}, 5'h1f);
      if (sel) begin
        if (stb) begin strobe_cnt++; got_strobe = 1; end
        else if (got_strobe) hold_cnt++;
        else setup_cnt++;
        if (stb && !p_stb) begin
          chk(setup_cnt == SETUP, "R4 setup length", setup_cnt, SETUP);
          chk({!bus_cs1_n, !bus_cs0_n} == exp_cs, "R11 selects", {!bus_cs1_n, !bus_cs0_n}, exp_cs);
          chk(bus_addr == exp_addr, "R11 address", bus_addr, exp_addr);
          chk(bus_d_oe == exp_write, "R3 direction", bus_d_oe, exp_write);
          chk(bus_wr_n == !exp_write && bus_rd_n == exp_write, "R5 strobe kind",
              {bus_rd_n, bus_wr_n}, {exp_write, !exp_write});
          if (exp_write) chk(bus_d_out == exp_bus, "R9 R8 write data at strobe", bus_d_out, exp_bus);
        end
        if (!stb && p_stb) begin
          chk(strobe_cnt == STROBE, "R5 strobe length", strobe_cnt, STROBE);
          if (exp_write) chk(bus_d_out == exp_bus && bus_d_oe, "R9 write data after strobe", bus_d_out, exp_bus);
        end
      end else begin
        if (p_sel) begin
          chk(hold_cnt == HOLD, "R6 hold length", hold_cnt, HOLD);
          chk(rsp_valid, "R7 done with release", rsp_valid, 1);
          seen++;
        end
        setup_cnt = 0; strobe_cnt = 0; hold_cnt = 0; got_strobe = 0;
      end
      if (!bus_rst_n) begin
        rst_cnt++;
        if (sel || stb || bus_d_oe) rst_clean = 0;
      end else if (!p_rstn) begin
        chk(rst_cnt == RSTLEN, "R10 reset length", rst_cnt, RSTLEN);
        chk(rsp_valid && rst_clean, "R10 done and quiet", {rsp_valid, rst_clean}, 2'b11);
        rst_cnt = 0; rst_clean = 1; seen++;
      end
      p_sel = sel; p_stb = stb; p_oe = bus_d_oe; p_rstn = bus_rst_n;
    end
  end

  task automatic access(input bit w, input logic [1:0] cs, input logic [2:0] a,
                        input bit wide, input logic [15:0] wd, input logic [15:0] dev,
                        input bit poke_busy);
    int n;
    logic [15:0] exp_rd;
    exp_write = w; exp_cs = cs; exp_addr = a;
    exp_bus = shape(wide, cs, a, wd);
    exp_rd  = shape(wide, cs, a, dev);
    dev_word = dev;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_hwrst = 0; req_write = w; req_cs = cs; req_addr = a; req_wide = wide; req_wdata = wd;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    issued++;
    chk(!req_ready, "R2 busy after accept", req_ready, 0);
    chk(bus_cs0_n && bus_cs1_n && bus_rd_n && bus_wr_n, "R4 turn cycle quiet",
        {bus_cs0_n, bus_cs1_n, bus_rd_n, bus_wr_n}, 4'hf);
    chk(bus_d_oe == w, "R3 direction set in turn cycle", bus_d_oe, w);
    if (poke_busy) begin
      req_valid = 1; req_write = !w; req_addr = ~a; req_wdata = ~wd; req_cs = ~cs;
      repeat (30) @(negedge clk);
      chk(!req_ready, "R2 still busy under poke", req_ready, 0);
      req_valid = 0;
    end
    n = 0;
    while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
    chk(rsp_valid, "R7 done arrives", rsp_valid, 1);
    if (!w) chk(rsp_rdata == exp_rd, "R7 R8 read data", rsp_rdata, exp_rd);
    chk(req_ready, "R2 ready with done", req_ready, 1);
    @(negedge clk);
    chk(!rsp_valid, "R7 single-cycle done", rsp_valid, 0);
  endtask

  task automatic hw_reset();
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_hwrst = 1; req_write = 1; req_valid = 1;
    @(negedge clk);
    req_valid = 0; req_hwrst = 0;
    issued++;
    chk(!bus_rst_n && !bus_d_oe, "R10 reset line low", {bus_rst_n, bus_d_oe}, 2'b00);
    n = 0;
    while (!rsp_valid && n < RSTLEN + 100) begin @(negedge clk); n++; end
    chk(rsp_valid && bus_rst_n, "R10 done after reset", {rsp_valid, bus_rst_n}, 2'b11);
    @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    chk(bus_cs0_n && bus_cs1_n && bus_rd_n && bus_wr_n && bus_rst_n && !bus_d_oe,
        "R1 controls in reset", {bus_cs0_n, bus_cs1_n, bus_rd_n, bus_wr_n, bus_rst_n, bus_d_oe}, 6'h3e);
    rst_n = 1;
    @(negedge clk);
    chk(bus_cs0_n && bus_cs1_n && bus_rd_n && bus_wr_n && bus_rst_n && !bus_d_oe && !rsp_valid && req_ready,
        "R1 state after reset",
        {bus_cs0_n, bus_cs1_n, bus_rd_n, bus_wr_n, bus_rst_n, bus_d_oe, rsp_valid, req_ready}, 8'hf9);

    // directed corners
    access(1, 2'b01, 3'd0, 1, 16'hBEEF, 16'h0000, 0);   // R8 wide write
    access(0, 2'b01, 3'd0, 1, 16'h0000, 16'hCAFE, 0);   // R8 wide read
    access(0, 2'b01, 3'd0, 0, 16'h0000, 16'h1234, 0);   // R8 narrow data register
    access(0, 2'b10, 3'd0, 1, 16'h0000, 16'h9A7C, 0);   // R8 alternate select, address 0
    access(1, 2'b01, 3'd7, 1, 16'hF0E1, 16'h0000, 0);   // R8 wide flag off data register
    access(0, 2'b10, 3'd6, 0, 16'h0000, 16'h00F7, 0);   // R11 alternate select
    access(1, 2'b01, 3'd3, 0, 16'h5501, 16'h0000, 1);   // R2 busy poke, write
    access(0, 2'b01, 3'd0, 1, 16'h0000, 16'h8001, 1);   // R2 busy poke, read
    hw_reset();                                          // R10
    access(0, 2'b01, 3'd7, 0, 16'h0000, 16'h0050, 0);

    for (int i = 0; i < 50; i++) begin
      bit w, wide, poke;
      logic [1:0] cs;
      w    = $urandom_range(0, 1);
      wide = $urandom_range(0, 1);
      poke = ($urandom_range(0, 7) == 0);
      cs   = ($urandom_range(0, 3) == 0) ? 2'b10 : 2'b01;
      access(w, cs, 3'($urandom_range(0, 7)), wide, 16'($urandom), 16'($urandom), poke);
    end
    hw_reset();

    repeat (5) @(negedge clk);
    chk(seen == issued, "R2 one bus cycle per accepted request", seen, issued);
    chk(bus_rst_n, "R10 reset line idle", bus_rst_n, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule